// File: doc/BRIEF.md
# Byte-Instruction Register-Machine CPU Core

This block is a small single-cycle processor core. Each instruction is one byte wide. The core presents a program counter on an instruction-address port and takes the addressed byte back on the same cycle. It executes that byte at the next rising clock edge. The data path is DW bits wide and holds six general registers. The core also has one input port and one output port, and both sit at selector code 6 of the register address space.

Bits [7:6] of each instruction pick one of four classes. Class 00 loads a six-bit immediate into R0. Class 01 combines R1 with R2 and writes the result to R3. Class 10 copies from a source selector to a destination selector. Class 11 branches to the address held in R0 when the signed value in R3 meets one of eight tests against zero.

The input and output ports carry registered strobes, so logic outside the core can tell when a word was consumed or produced. The core has no data memory, no stack, no interrupts, no carry flag and no pipeline.

Top module: `octet_cpu`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, R0 to R5, `out_data`, `out_vld` and `in_ack` to zero.
- R2: An instruction 00iiiiii writes the value iiiiii, zero-extended to DW bits, into R0.
- R3: An instruction 01xxxooo writes f(R1,R2) into R3, where ooo selects the function: 000 OR, 001 NAND, 010 NOR, 011 AND, 100 ADD, 101 SUB.
- R4: ADD returns (R1+R2) modulo 2^DW and produces no carry. SUB returns (R1-R2) modulo 2^DW in two's complement.
- R5: Calculate codes 110 and 111 change no register.
- R6: An instruction 10sssddd with ddd in 0..5 writes into register Rddd the value of source sss. Source codes 0..5 read R0..R5.
- R7: Source code 6 reads `in_data`. For such a copy, `in_ack` is high for exactly the one cycle after the executing edge.
- R8: Destination code 6 loads the copied value into `out_data` and raises `out_vld` for one cycle. At all other times `out_data` holds its value.
- R9: Source code 7 reads as zero. Destination code 7 changes no register and no output.
- R10: An instruction 11xxxccc loads the program counter from R0 when R3, read as signed, meets condition ccc: 000 never, 001 =0, 010 <0, 011 <=0, 100 always, 101 !=0, 110 >=0, 111 >0.
- R11: For every instruction that does not branch, the program counter advances by one and wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | AW | Program counter, the address of the instruction to execute |
| imem_data | input | 8 | Instruction byte at `imem_addr`, read combinationally |
| in_data | input | DW | Input port word, read by copies from source 6 |
| in_ack | output | 1 | One-cycle strobe after the input word was consumed |
| out_data | output | DW | Output port word, registered |
| out_vld | output | 1 | One-cycle strobe marking a new `out_data` word |

## Verification
Each instruction is presented before a rising edge and takes effect at that edge. The new program counter, `out_data`, `out_vld` and `in_ack` are therefore all due one edge later, and the bench samples them at the following falling edge. Register contents are not visible at the ports, so the bench copies each register to the output port. The copied value becomes visible one edge after that copy. On every cycle the bench compares the port values with a model computed from the requirements, advanced by one instruction per cycle. The sweeps cover every ALU function over a 16-by-16 operand grid, every immediate value, the full 8-by-8 copy matrix, and all eight branch conditions against values at and around zero and the sign boundary.

// File: rtl/octet_cpu_pkg.sv
package octet_cpu_pkg;

  localparam int unsigned INSTR_W = 8;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned IMM_W   = 6;
  localparam int unsigned NUM_GPR = 6;

  localparam logic [SEL_W-1:0] PORT_SEL = 3'd6;
  localparam logic [SEL_W-1:0] IMM_DST  = 3'd0;
  localparam logic [SEL_W-1:0] ALU_DST  = 3'd3;

  typedef enum logic [1:0] {
    CLS_IMM  = 2'b00,
    CLS_CALC = 2'b01,
    CLS_COPY = 2'b10,
    CLS_JUMP = 2'b11
  } cls_e;

  typedef enum logic [2:0] {
    ALU_OR   = 3'd0,
    ALU_NAND = 3'd1,
    ALU_NOR  = 3'd2,
    ALU_AND  = 3'd3,
    ALU_ADD  = 3'd4,
    ALU_SUB  = 3'd5,
    ALU_RSV6 = 3'd6,
    ALU_RSV7 = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    CND_NEVER  = 3'd0,
    CND_EQZ    = 3'd1,
    CND_LTZ    = 3'd2,
    CND_LEZ    = 3'd3,
    CND_ALWAYS = 3'd4,
    CND_NEZ    = 3'd5,
    CND_GEZ    = 3'd6,
    CND_GTZ    = 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    WSRC_IMM  = 2'd0,
    WSRC_ALU  = 2'd1,
    WSRC_MOVE = 2'd2
  } wsrc_e;

  typedef struct packed {
    logic             wr_en;
    logic [SEL_W-1:0] wr_sel;
    wsrc_e            wr_src;
    logic             out_en;
    logic             in_rd;
    logic             is_jump;
    alu_op_e          alu_op;
    cond_e            cond;
    logic [SEL_W-1:0] src_sel;
    logic [IMM_W-1:0] imm;
  } dec_t;

endpackage

// File: rtl/octet_cpu_decode.sv
module octet_cpu_decode
  import octet_cpu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  logic [SEL_W-1:0] fld_hi;
  logic [SEL_W-1:0] fld_lo;

  assign fld_hi = instr[5:3];
  assign fld_lo = instr[2:0];

  always_comb begin
    dec.wr_en   = 1'b0;
    dec.wr_sel  = IMM_DST;
    dec.wr_src  = WSRC_IMM;
    dec.out_en  = 1'b0;
    dec.in_rd   = 1'b0;
    dec.is_jump = 1'b0;
    dec.alu_op  = alu_op_e'(fld_lo);
    dec.cond    = cond_e'(fld_lo);
    dec.src_sel = fld_hi;
    dec.imm     = instr[IMM_W-1:0];
    unique case (cls_e'(instr[7:6]))
      CLS_IMM: begin
        dec.wr_en  = 1'b1;
        dec.wr_sel = IMM_DST;
      end
      CLS_CALC: begin
        dec.wr_en  = (fld_lo[2:1] != 2'b11);
        dec.wr_sel = ALU_DST;
        dec.wr_src = WSRC_ALU;
      end
      CLS_COPY: begin
        dec.wr_en  = (fld_lo < SEL_W'(NUM_GPR));
        dec.wr_sel = fld_lo;
        dec.wr_src = WSRC_MOVE;
        dec.out_en = (fld_lo == PORT_SEL);
        dec.in_rd  = (fld_hi == PORT_SEL);
      end
      CLS_JUMP: begin
        dec.is_jump = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/octet_cpu_regfile.sv
module octet_cpu_regfile
  import octet_cpu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [DW-1:0]    wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    r0,
  output logic [DW-1:0]    r1,
  output logic [DW-1:0]    r2,
  output logic [DW-1:0]    r3
);

  logic [NUM_GPR-1:0][DW-1:0] bank;

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (we && (wsel == SEL_W'(g))) begin
        q <= wdata;
      end
    end
    assign bank[g] = q;
  end

  // Selectors beyond the register bank read as zero.
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_GPR; i++) begin
      if (rsel == SEL_W'(i)) rdata = bank[i];
    end
  end

  assign r0 = bank[0];
  assign r1 = bank[1];
  assign r2 = bank[2];
  assign r3 = bank[3];

endmodule

// File: rtl/octet_cpu_alu.sv
module octet_cpu_alu
  import octet_cpu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_OR:   y = a | b;
      ALU_NAND: y = ~(a & b);
      ALU_NOR:  y = ~(a | b);
      ALU_AND:  y = a & b;
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/octet_cpu_cond.sv
module octet_cpu_cond
  import octet_cpu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] val,
  input  cond_e         cond,
  output logic          take
);

  logic is_neg;
  logic is_zero;

  assign is_neg  = val[DW-1];
  assign is_zero = (val == '0);

  always_comb begin
    unique case (cond)
      CND_NEVER:  take = 1'b0;
      CND_EQZ:    take = is_zero;
      CND_LTZ:    take = is_neg;
      CND_LEZ:    take = is_neg | is_zero;
      CND_ALWAYS: take = 1'b1;
      CND_NEZ:    take = ~is_zero;
      CND_GEZ:    take = ~is_neg;
      CND_GTZ:    take = ~is_neg & ~is_zero;
      default:    take = 1'b0;
    endcase
  end

endmodule

// File: rtl/octet_cpu.sv
module octet_cpu
  import octet_cpu_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [AW-1:0]      imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  input  logic [DW-1:0]      in_data,
  output logic               in_ack,
  output logic [DW-1:0]      out_data,
  output logic               out_vld
);

  dec_t          dec;
  logic [DW-1:0] r0_val, r1_val, r2_val, r3_val;
  logic [DW-1:0] rf_rd, move_val, alu_y, wr_data;
  logic          take;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] out_q;
  logic          out_vld_q;
  logic          in_ack_q;

  octet_cpu_decode u_dec (
    .instr (imem_data),
    .dec   (dec)
  );

  octet_cpu_regfile #(.DW(DW)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (dec.wr_en),
    .wsel  (dec.wr_sel),
    .wdata (wr_data),
    .rsel  (dec.src_sel),
    .rdata (rf_rd),
    .r0    (r0_val),
    .r1    (r1_val),
    .r2    (r2_val),
    .r3    (r3_val)
  );

  octet_cpu_alu #(.DW(DW)) u_alu (
    .a  (r1_val),
    .b  (r2_val),
    .op (dec.alu_op),
    .y  (alu_y)
  );

  octet_cpu_cond #(.DW(DW)) u_cnd (
    .val  (r3_val),
    .cond (dec.cond),
    .take (take)
  );

  assign move_val = (dec.src_sel == PORT_SEL) ? in_data : rf_rd;

  always_comb begin
    unique case (dec.wr_src)
      WSRC_ALU:  wr_data = alu_y;
      WSRC_MOVE: wr_data = move_val;
      default:   wr_data = DW'(dec.imm);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (dec.is_jump && take) begin
      pc_q <= AW'(r0_val);
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= '0;
      out_vld_q <= 1'b0;
      in_ack_q  <= 1'b0;
    end else begin
      out_vld_q <= dec.out_en;
      in_ack_q  <= dec.in_rd;
      if (dec.out_en) out_q <= move_val;
    end
  end

  assign imem_addr = pc_q;
  assign out_data  = out_q;
  assign out_vld   = out_vld_q;
  assign in_ack    = in_ack_q;

endmodule

// File: rtl/octet_cpu_chk.sv
module octet_cpu_chk
  import octet_cpu_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      imem_addr,
  input logic [INSTR_W-1:0] imem_data,
  input logic               in_ack,
  input logic [DW-1:0]      out_data,
  input logic               out_vld,
  input logic [DW-1:0]      r0
);

  logic cp_to_out, cp_from_in, is_br, br_always, br_never;

  assign cp_to_out  = (imem_data[7:6] == 2'b10) && (imem_data[2:0] == 3'd6);
  assign cp_from_in = (imem_data[7:6] == 2'b10) && (imem_data[5:3] == 3'd6);
  assign is_br      = (imem_data[7:6] == 2'b11);
  assign br_always  = is_br && (imem_data[2:0] == 3'd4);
  assign br_never   = is_br && (imem_data[2:0] == 3'd0);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (imem_addr == '0) && !out_vld && !in_ack && (out_data == '0));

  // R8
  p_out_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(cp_to_out));

  // R8
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cp_to_out |=> $stable(out_data) && !out_vld);

  // R7
  p_in_ack_r7: assert property (@(posedge clk) disable iff (rst)
    cp_from_in |=> in_ack);

  // R7
  p_in_ack_src_r7: assert property (@(posedge clk) disable iff (rst)
    in_ack |-> $past(cp_from_in));

  // R11
  p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
    !is_br |=> imem_addr == AW'($past(imem_addr) + 1'b1));

  // R10
  p_br_never_r10: assert property (@(posedge clk) disable iff (rst)
    br_never |=> imem_addr == AW'($past(imem_addr) + 1'b1));

  // R10
  p_br_always_r10: assert property (@(posedge clk) disable iff (rst)
    br_always |=> imem_addr == AW'($past(r0)));

endmodule

bind octet_cpu octet_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .imem_data (imem_data),
  .in_ack    (in_ack),
  .out_data  (out_data),
  .out_vld   (out_vld),
  .r0        (r0_val)
);

// File: tb/octet_cpu_tb_top.sv
`timescale 1ns/1ps
module octet_cpu_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] imem_data = 8'h00;
  logic [7:0] in_data = 8'h00;
  logic [7:0] imem_addr;
  logic [7:0] out_data;
  logic       out_vld;
  logic       in_ack;

  int n_run  = 0;
  int n_fail = 0;

  logic [7:0] m_reg [6];
  logic [7:0] m_pc;
  logic [7:0] m_out;

  always #2 clk = ~clk;

  octet_cpu #(.DW(8), .AW(8)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .in_data   (in_data),
    .in_ack    (in_ack),
    .out_data  (out_data),
    .out_vld   (out_vld)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] f_cp(input int s, input int d);
    return {2'b10, 3'(s), 3'(d)};
  endfunction

  function automatic logic [7:0] f_val(input int i);
    if (i == 0) return 8'h00;
    if (i == 15) return 8'hff;
    return 8'(i * 73 + 5);
  endfunction

  // One instruction per cycle; called and returns at a falling edge.
  task automatic step(input logic [7:0] ins, input logic [7:0] din, input string req);
    logic [7:0] e_pc, a, b, v, res;
    logic       e_vld, e_ack, tk;
    int         s, d, op;
    e_pc  = m_pc + 8'd1;
    e_vld = 1'b0;
    e_ack = 1'b0;
    case (ins[7:6])
      2'b00: m_reg[0] = {2'b00, ins[5:0]};
      2'b01: begin
        a = m_reg[1]; b = m_reg[2]; op = int'(ins[2:0]);
        case (op)
          0: res = a | b;
          1: res = ~(a & b);
          2: res = ~(a | b);
          3: res = a & b;
          4: res = 8'(int'(a) + int'(b));
          5: res = 8'(int'(a) - int'(b));
          default: res = m_reg[3];
        endcase
        m_reg[3] = res;
      end
      2'b10: begin
        s = int'(ins[5:3]); d = int'(ins[2:0]);
        v = (s < 6) ? m_reg[s] : ((s == 6) ? din : 8'h00);
        if (s == 6) e_ack = 1'b1;
        if (d < 6) m_reg[d] = v;
        else if (d == 6) begin e_vld = 1'b1; m_out = v; end
      end
      default: begin
        case (int'(ins[2:0]))
          0: tk = 1'b0;
          1: tk = $signed(m_reg[3]) == 0;
          2: tk = $signed(m_reg[3]) < 0;
          3: tk = $signed(m_reg[3]) <= 0;
          4: tk = 1'b1;
          5: tk = $signed(m_reg[3]) != 0;
          6: tk = $signed(m_reg[3]) >= 0;
          default: tk = $signed(m_reg[3]) > 0;
        endcase
        if (tk) e_pc = m_reg[0];
      end
    endcase
    imem_data = ins;
    in_data   = din;
    @(posedge clk);
    @(negedge clk);
    m_pc = e_pc;
    check(imem_addr == m_pc, req, "pc", 32'(imem_addr), 32'(m_pc));
    check(out_vld == e_vld, req, "out_vld", 32'(out_vld), 32'(e_vld));
    check(out_data == m_out, req, "out_data", 32'(out_data), 32'(m_out));
    check(in_ack == e_ack, req, "in_ack", 32'(in_ack), 32'(e_ack));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    imem_data = 8'h00;
    in_data = 8'h00;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(imem_addr == 8'h00, "R1", "reset pc", 32'(imem_addr), 0);
    check(out_vld == 1'b0, "R1", "reset out_vld", 32'(out_vld), 0);
    check(out_data == 8'h00, "R1", "reset out_data", 32'(out_data), 0);
    check(in_ack == 1'b0, "R1", "reset in_ack", 32'(in_ack), 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) m_reg[i] = 8'h00;
    m_pc = 8'h00;
    m_out = 8'h00;
    for (int r = 0; r < 6; r++) step(f_cp(r, 6), 8'h00, "R1");
  endtask

  task automatic dump_all(input string req);
    for (int r = 0; r < 6; r++) step(f_cp(r, 6), 8'h00, req);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();

    // R2: every immediate value
    for (int v = 0; v < 64; v++) begin
      step({2'b00, 6'(v)}, 8'h00, "R2");
      step(f_cp(0, 6), 8'h00, "R2");
    end

    // R3 and R4: every function over an operand grid
    for (int op = 0; op < 6; op++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          step(f_cp(6, 1), f_val(i), "R7");
          step(f_cp(6, 2), f_val(j), "R7");
          step({2'b01, 3'b000, 3'(op)}, 8'h00, (op >= 4) ? "R4" : "R3");
          step(f_cp(3, 6), 8'h00, (op >= 4) ? "R4" : "R3");
        end
      end
    end

    // R5: reserved calculate codes
    for (int op = 6; op < 8; op++) begin
      step(f_cp(6, 1), 8'h3c, "R7");
      step(f_cp(6, 2), 8'hc5, "R7");
      step(f_cp(6, 3), 8'ha5, "R7");
      step({2'b01, 3'b101, 3'(op)}, 8'h00, "R5");
      dump_all("R5");
    end

    // R6, R7, R8, R9: full copy matrix
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 8; d++) begin
        for (int r = 0; r < 6; r++) step(f_cp(6, r), 8'(8'h11 * (r + 1) + s), "R7");
        step(f_cp(s, d), 8'h5a, (s == 7 || d == 7) ? "R9" : ((d == 6) ? "R8" : "R6"));
        dump_all((d == 7) ? "R9" : "R6");
      end
    end

    // R10: every condition against signed boundary values
    for (int k = 0; k < 7; k++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] t;
        case (k)
          0: t = 8'h00; 1: t = 8'h01; 2: t = 8'h7f; 3: t = 8'h80;
          4: t = 8'hff; 5: t = 8'h40; default: t = 8'hc0;
        endcase
        step(f_cp(6, 3), t, "R7");
        step({2'b00, 6'(c * 7 + 3)}, 8'h00, "R2");
        step({2'b11, 3'b000, 3'(c)}, 8'h00, "R10");
      end
    end

    // R11: wrap of the program counter
    step(f_cp(6, 0), 8'hfe, "R7");
    step({2'b11, 3'b000, 3'd4}, 8'h00, "R10");
    for (int n = 0; n < 4; n++) step(f_cp(7, 7), 8'h00, "R11");
    for (int n = 0; n < 300; n++) step(f_cp(7, 7), 8'h00, "R11");

    // R1: reset again after activity
    step(f_cp(6, 4), 8'h99, "R7");
    step(f_cp(4, 6), 8'h00, "R8");
    do_reset();

    finish_run();
  end

endmodule